// File: doc/BRIEF.md
# Shift, Rotate and Bit-Test Unit

A purely combinational datapath slice for an 8-bit accumulator-style processor core. It takes one operand byte, the current flag byte, a 4-bit operation select and a 3-bit bit index. In the same cycle it returns the rotated, shifted or unchanged operand and the new flag byte. The instruction decoder picks the operation. Register-file and memory plumbing sit outside this unit.

Twelve of the operation codes move bits. There are eight prefixed-group shifts and rotates, which all update the flags fully. There are four accumulator fast rotates, which update only the carry and clear the half-carry and subtract flags. One code tests a single bit. The codes that remain are pass-through.

Top module: `shrot_unit`

## Requirements
- R1: Code 0 rotates left circularly (result = {x[6:0],x[7]}, C = x[7]); code 1 rotates right circularly (result = {x[0],x[7:1]}, C = x[0]).
- R2: Code 2 rotates left through carry (result = {x[6:0],Cin}, C = x[7]); code 3 rotates right through carry (result = {Cin,x[7:1]}, C = x[0]). For example, 0x08 with Cin=1 under code 3 gives 0x84 and flags 0x84.
- R3: Code 4 shifts left with 0 into bit 0 (C = x[7]); code 5 shifts right keeping bit 7 (C = x[0]).
- R4: Code 7 shifts right with 0 into bit 7, and C = x[0] whatever Cin is. For example, 0x10 with flags 0x01 gives 0x08 and flags 0x00.
- R5: Code 6 shifts left with 1 forced into bit 0 (C = x[7]). For example, 0x48 gives 0x91 with flags 0x80, and 0x08 gives 0x11 with flags 0x04.
- R6: The flag byte layout is S=bit7, Z=bit6, H=bit4, P/V=bit2, N=bit1, C=bit0. For codes 0 to 7, S = result bit 7, Z = (result == 0), P/V = 1 when the result has an even number of ones, and H = N = 0.
- R7: Codes 8, 9, 10 and 11 give the same result and C as codes 0, 1, 2 and 3. They clear H and N and keep S, Z and P/V from the incoming flags. For example, code 9 on 0x12 with flags 0xFF gives 0x09 and flags 0xEC.
- R8: Code 12 tests operand bit n, where n is the bit index. The result equals the operand. Z = P/V = NOT(tested bit), H = 1, N = 0, C is kept, and S = 1 only when n = 7 and the tested bit is 1.
- R9: Flag bits 5 and 3 are copied from the incoming flag byte for every code.
- R10: Codes 13, 14 and 15 return the operand and the incoming flag byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 8 | Operand byte |
| flags_i | input | 8 | Incoming flag byte |
| op_i | input | 4 | Operation select code |
| bit_sel_i | input | 3 | Bit index for the bit test |
| result_o | output | 8 | Result byte |
| flags_o | output | 8 | Updated flag byte |

## Verification
The two functions that meet in one evaluation are the carry produced by the shifter and the incoming flags passed through for the fields that an operation must not touch. This matters most for the fast rotates and the bit test, which write some flag bits and keep others. The bench changes the operation, the operand and a random flag byte on every clock, so that each operation follows the others back to back with the set flags varying. It judges each cycle by comparing the whole result and flag byte against a behavioural model. The model works on integers and rebuilds each flag bit from the requirements.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

  localparam int FLAG_W = 8;

  // flag byte bit positions (decoded by the neighbouring condition logic)
  localparam int F_S = 7;
  localparam int F_Z = 6;
  localparam int F_Y = 5;
  localparam int F_H = 4;
  localparam int F_X = 3;
  localparam int F_P = 2;
  localparam int F_N = 1;
  localparam int F_C = 0;

  typedef enum logic [3:0] {
    OP_RLC  = 4'd0,
    OP_RRC  = 4'd1,
    OP_RL   = 4'd2,
    OP_RR   = 4'd3,
    OP_SLA  = 4'd4,
    OP_SRA  = 4'd5,
    OP_SLL  = 4'd6,
    OP_SRL  = 4'd7,
    OP_RLCA = 4'd8,
    OP_RRCA = 4'd9,
    OP_RLA  = 4'd10,
    OP_RRA  = 4'd11,
    OP_BIT  = 4'd12
  } shrot_op_e;

endpackage

// File: rtl/shrot_shift.sv
// Single-position shifter. sel[0] picks the direction (1 = right),
// sel[2:1] picks the bit that enters the vacated end.
module shrot_shift #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] opnd_i,
  input  logic [2:0]    sel_i,
  input  logic          cin_i,
  output logic [DW-1:0] res_o,
  output logic          cout_o
);

  logic fill_bit;
  logic go_right;

  assign go_right = sel_i[0];

  always_comb begin
    fill_bit = 1'b0;
    unique case (sel_i[2:1])
      2'b00: fill_bit = go_right ? opnd_i[0] : opnd_i[DW-1];   // circular
      2'b01: fill_bit = cin_i;                                  // through carry
      2'b10: fill_bit = go_right ? opnd_i[DW-1] : 1'b0;         // arithmetic
      2'b11: fill_bit = go_right ? 1'b0 : 1'b1;                 // logical / set-fill
      default: fill_bit = 1'b0;
    endcase
  end

  always_comb begin
    if (go_right) begin
      res_o  = {fill_bit, opnd_i[DW-1:1]};
      cout_o = opnd_i[0];
    end else begin
      res_o  = {opnd_i[DW-2:0], fill_bit};
      cout_o = opnd_i[DW-1];
    end
  end

endmodule

// File: rtl/shrot_parity.sv
// Even-parity detector built as a ripple of XOR stages.
module shrot_parity #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] data_i,
  output logic          even_o
);

  logic [DW:0] chain;

  assign chain[0] = 1'b0;

  for (genvar gi = 0; gi < DW; gi++) begin : g_xor
    assign chain[gi+1] = chain[gi] ^ data_i[gi];
  end

  assign even_o = ~chain[DW];

endmodule

// File: rtl/shrot_bittest.sv
// Selects one operand bit by index through a one-hot decode.
module shrot_bittest #(
  parameter int DW = 8,
  localparam int IW = $clog2(DW)
) (
  input  logic [DW-1:0] opnd_i,
  input  logic [IW-1:0] sel_i,
  output logic          bit_o,
  output logic          top_o
);

  logic [DW-1:0] hot;

  for (genvar gi = 0; gi < DW; gi++) begin : g_dec
    assign hot[gi] = (sel_i == IW'(gi));
  end

  assign bit_o = |(hot & opnd_i);
  assign top_o = hot[DW-1];

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int DW = 8,
  localparam int IW = $clog2(DW)
) (
  input  logic [DW-1:0]     opnd_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [3:0]        op_i,
  input  logic [IW-1:0]     bit_sel_i,
  output logic [DW-1:0]     result_o,
  output logic [FLAG_W-1:0] flags_o
);

  logic [DW-1:0] sh_res;
  logic          sh_cout;
  logic          par_even;
  logic          tst_bit;
  logic          tst_top;
  logic          is_cb;
  logic          is_fast;
  logic          is_bit;

  assign is_cb   = (op_i[3] == 1'b0);
  assign is_fast = (op_i[3:2] == 2'b10);
  assign is_bit  = (op_i == OP_BIT);

  shrot_shift #(.DW(DW)) u_shift (
    .opnd_i (opnd_i),
    .sel_i  (op_i[2:0]),
    .cin_i  (flags_i[F_C]),
    .res_o  (sh_res),
    .cout_o (sh_cout)
  );

  shrot_parity #(.DW(DW)) u_par (
    .data_i (sh_res),
    .even_o (par_even)
  );

  shrot_bittest #(.DW(DW)) u_bit (
    .opnd_i (opnd_i),
    .sel_i  (bit_sel_i),
    .bit_o  (tst_bit),
    .top_o  (tst_top)
  );

  always_comb begin
    result_o = opnd_i;
    flags_o  = flags_i;
    if (is_cb) begin
      result_o     = sh_res;
      flags_o[F_S] = sh_res[DW-1];
      flags_o[F_Z] = (sh_res == '0);
      flags_o[F_H] = 1'b0;
      flags_o[F_P] = par_even;
      flags_o[F_N] = 1'b0;
      flags_o[F_C] = sh_cout;
    end else if (is_fast) begin
      result_o     = sh_res;
      flags_o[F_H] = 1'b0;
      flags_o[F_N] = 1'b0;
      flags_o[F_C] = sh_cout;
    end else if (is_bit) begin
      flags_o[F_S] = tst_bit & tst_top;
      flags_o[F_Z] = ~tst_bit;
      flags_o[F_H] = 1'b1;
      flags_o[F_P] = ~tst_bit;
      flags_o[F_N] = 1'b0;
    end
  end

  always_comb begin
    // R1
    cb_carry_chk: assert (!is_cb ||
      flags_o[F_C] == (op_i[0] ? opnd_i[0] : opnd_i[DW-1]));
    // R7
    fast_keep_chk: assert (!is_fast ||
      (flags_o[F_S] == flags_i[F_S] && flags_o[F_Z] == flags_i[F_Z] &&
       flags_o[F_P] == flags_i[F_P] && !flags_o[F_H] && !flags_o[F_N]));
    // R8
    bit_same_chk: assert (!is_bit ||
      (result_o == opnd_i && flags_o[F_P] == flags_o[F_Z] &&
       flags_o[F_C] == flags_i[F_C]));
    // R9
    undoc_keep_chk: assert (flags_o[F_Y] == flags_i[F_Y] &&
                            flags_o[F_X] == flags_i[F_X]);
    // R6
    cb_zero_chk: assert (!is_cb || flags_o[F_Z] == (result_o == '0));
  end

endmodule

// File: tb/shrot_unit_tb.sv
module shrot_unit_tb;

  logic       clk;
  logic       rst_n;
  logic [7:0] opnd_i;
  logic [7:0] flags_i;
  logic [3:0] op_i;
  logic [2:0] bit_sel_i;
  logic [7:0] result_o;
  logic [7:0] flags_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  shrot_unit u_dut (
    .opnd_i    (opnd_i),
    .flags_i   (flags_i),
    .op_i      (op_i),
    .bit_sel_i (bit_sel_i),
    .result_o  (result_o),
    .flags_o   (flags_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int even_par(input int v);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += (v >> i) & 1;
    return ((ones % 2) == 0) ? 1 : 0;
  endfunction

  function automatic string tag_of(input int op);
    case (op)
      0, 1:    return "R1";
      2, 3:    return "R2";
      4, 5:    return "R3";
      6:       return "R5";
      7:       return "R4";
      8, 9, 10, 11: return "R7";
      12:      return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic model(input int op, input int x, input int f, input int n,
                       output int r, output int fo);
    int c  = f & 1;
    int b  = op & 7;
    int res = x;
    int co = 0;
    r  = x;
    fo = f;
    if (op < 12) begin
      case (b)
        0: begin res = ((x << 1) | (x >> 7)) & 255; co = (x >> 7) & 1; end
        1: begin res = (x >> 1) | ((x & 1) << 7);   co = x & 1; end
        2: begin res = ((x << 1) | c) & 255;        co = (x >> 7) & 1; end
        3: begin res = (x >> 1) | (c << 7);         co = x & 1; end
        4: begin res = (x << 1) & 255;              co = (x >> 7) & 1; end
        5: begin res = (x >> 1) | (x & 128);        co = x & 1; end
        6: begin res = ((x << 1) | 1) & 255;        co = (x >> 7) & 1; end
        default: begin res = x >> 1;                co = x & 1; end
      endcase
      r = res;
      if (op < 8)
        fo = (f & 'h28) | (res & 128) | ((res == 0) ? 64 : 0) |
             (even_par(res) ? 4 : 0) | co;
      else
        fo = (f & 'hEC) | co;
    end else if (op == 12) begin
      int tb = (x >> n) & 1;
      fo = (f & 'h29) | 16 | ((tb == 0) ? 68 : 0) | ((n == 7 && tb == 1) ? 128 : 0);
    end
  endtask

  task automatic check_vec(input int op, input int x, input int f, input int n,
                           input int er, input int ef, input string tag);
    @(posedge clk);
    #1;
    op_i      = op[3:0];
    opnd_i    = x[7:0];
    flags_i   = f[7:0];
    bit_sel_i = n[2:0];
    @(negedge clk);
    checks++;
    if (result_o !== er[7:0] || flags_o !== ef[7:0]) begin
      errors++;
      $display("FAIL %s op=%0d x=%02h f=%02h n=%0d: result=%02h flags=%02h expected result=%02h flags=%02h",
               tag, op, x, f, n, result_o, flags_o, er[7:0], ef[7:0]);
    end
  endtask

  task automatic check_model(input int op, input int x, input int f, input int n);
    int er, ef;
    model(op, x, f, n, er, ef);
    check_vec(op, x, f, n, er, ef, tag_of(op));
  endtask

  initial begin
    rst_n     = 1'b0;
    op_i      = 4'd15;
    opnd_i    = '0;
    flags_i   = '0;
    bit_sel_i = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset state: idle code with zero inputs returns zeros (R10)
    check_vec(15, 'h00, 'h00, 0, 'h00, 'h00, "R10");

    // R1 circular rotates
    check_vec(0, 'h80, 'h00, 0, 'h01, 'h01, "R1");
    check_vec(1, 'h01, 'h00, 0, 'h80, 'h81, "R1");
    // R2 rotate right through carry
    check_vec(3, 'h08, 'h01, 0, 'h84, 'h84, "R2");
    // R3 arithmetic shifts
    check_vec(5, 'h81, 'h00, 0, 'hC0, 'h85, "R3");
    check_vec(4, 'h81, 'h00, 0, 'h02, 'h01, "R3");
    // R4 logical right shift ignores incoming carry
    check_vec(7, 'h10, 'h01, 0, 'h08, 'h00, "R4");
    // R5 set-fill left shift
    check_vec(6, 'h48, 'h00, 0, 'h91, 'h80, "R5");
    check_vec(6, 'h08, 'h00, 0, 'h11, 'h04, "R5");
    // R6 zero result
    check_vec(7, 'h01, 'h00, 0, 'h00, 'h45, "R6");
    // R7 fast rotate keeps S Z P/V
    check_vec(9, 'h12, 'hFF, 0, 'h09, 'hEC, "R7");
    // R9 bits 5 and 3 pass through
    check_vec(10, 'h01, 'h28, 0, 'h02, 'h28, "R9");
    // R8 bit test, every index, tested bit clear, carry kept
    for (int k = 0; k < 8; k++)
      check_vec(12, (~(1 << k)) & 255, 'h01, k, (~(1 << k)) & 255, 'h55, "R8");
    check_vec(12, 'h80, 'h00, 7, 'h80, 'h90, "R8");
    // R10 unused codes
    check_vec(14, 'h5A, 'hC3, 3, 'h5A, 'hC3, "R10");

    // back-to-back sweep with random operand, flags and index
    for (int rep = 0; rep < 60; rep++)
      for (int op = 0; op < 16; op++)
        check_model(op, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                    int'($urandom_range(0, 7)));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule